// File: doc/BRIEF.md
# Per-Pin Edge Event Generator

This block watches sixteen general-purpose pad levels and raises a one-cycle event on a pin's own output whenever that pin shows an edge it has been armed for. The level is taken straight from the pad, so an edge counts whether the pad is being driven from outside or by the chip itself. Software that toggles its own output pin therefore gets an event for that change. The combined interrupt line is high in any cycle in which at least one pin event is high. The interrupt controller and the DMA controller take these outputs downstream.

Each pin is armed by two hidden mask bits, one for rising edges and one for falling edges. Software cannot address the masks directly. It changes them only by writing ones to set or clear aliases, and it reads them back through either alias. A single bank enable bit gates every event. The pad inputs pass through a synchronizer clocked by the peripheral clock before any edge is detected.

Top module: `pin_edge_event`

## Requirements
- R1: After reset both trigger masks and the bank enable are 0, no pin event or interrupt is high, and every register read returns 0.
- R2: A write to offset 0x24 sets the rising-mask bits that are 1 in write data bits 15:0. A write to offset 0x2C does the same for the falling mask. Zero bits leave the mask unchanged.
- R3: A write to offset 0x28 clears the rising-mask bits that are 1 in write data bits 15:0. A write to offset 0x30 does the same for the falling mask. Zero bits leave the mask unchanged.
- R4: A read at 0x24 or 0x28 returns the rising mask in bits 15:0, and a read at 0x2C or 0x30 returns the falling mask there. A read at 0x08 returns the bank enable in bit 0. Bits 31:16, the unused bits at 0x08 and every unmapped offset read as 0.
- R5: Bit 0 of a write to offset 0x08 sets the bank enable. While the bank enable is 0, no pin event is produced.
- R6: A pin's mask pair (rise,fall) selects its edges: 00 gives no event, 01 an event on falling edges only, 10 an event on rising edges only, and 11 an event on both edges.
- R7: Edges are judged on the synchronized level, comparing the current sample with the previous one. A pad change that sits before clock edge 0 shows as a one-cycle pulse on that pin's event bit after edge 2. The masks and bank enable in force just before edge 2 decide whether the pulse appears.
- R8: The interrupt output is high exactly in the cycles when any pin event bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinRaw | input | 16 | Pad levels, asynchronous to clk |
| busWrEn | input | 1 | Register write strobe, one cycle per write |
| busAddr | input | 8 | Byte offset for the write and the read |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| pinEvent | output | 16 | One-cycle event pulse for each pin |
| irqAny | output | 1 | OR of all pin events |

## Verification
A wrong mask bit or bank enable state is visible in two places. It shows at once on a read of the matching alias or offset. It also shows three clocks after the next pad edge, as a pulse that is missing or that should not be there. A fault in the synchronizer or the previous-sample register shows as a pulse that is one cycle early, late or too long. The bench finds these by comparing every cycle against a model built from the requirements. Directed steps cover each of the four encodings and the disabled bank.

// File: rtl/pin_edge_event_pkg.sv
package pin_edge_event_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h30;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic setRise;
    logic clrRise;
    logic setFall;
    logic clrFall;
    logic bankWr;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_BANK,
    RD_RISE,
    RD_FALL
  } rdSel_e;
endpackage

// File: rtl/pin_edge_event_ctrl.sv
module pin_edge_event_ctrl
  import pin_edge_event_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [NUM_PINS-1:0] riseMask,
  input  logic [NUM_PINS-1:0] fallMask,
  input  logic                bankEn,
  output wrStrobe_t           strb,
  output logic [NUM_PINS-1:0] wrBits,
  output logic                bankBit,
  output logic [DATA_W-1:0]   busRdData
);
  localparam int PAD_W = DATA_W - NUM_PINS;

  rdSel_e rdSel;
  logic   unusedWrHi;

  assign wrBits     = busWrData[NUM_PINS-1:0];
  assign bankBit    = busWrData[0];
  assign unusedWrHi = ^busWrData[DATA_W-1:NUM_PINS];

  always_comb begin
    strb = '0;
    if (busWrEn) begin
      unique case (busAddr)
        OFS_RISE_SET: strb.setRise = 1'b1;
        OFS_RISE_CLR: strb.clrRise = 1'b1;
        OFS_FALL_SET: strb.setFall = 1'b1;
        OFS_FALL_CLR: strb.clrFall = 1'b1;
        OFS_BANK_EN:  strb.bankWr  = 1'b1;
        default:      strb         = '0;
      endcase
    end
  end

  always_comb begin
    unique case (busAddr)
      OFS_BANK_EN:                 rdSel = RD_BANK;
      OFS_RISE_SET, OFS_RISE_CLR:  rdSel = RD_RISE;
      OFS_FALL_SET, OFS_FALL_CLR:  rdSel = RD_FALL;
      default:                     rdSel = RD_NONE;
    endcase
  end

  always_comb begin
    unique case (rdSel)
      RD_BANK: busRdData = {{(DATA_W-1){1'b0}}, bankEn};
      RD_RISE: busRdData = {{PAD_W{1'b0}}, riseMask};
      RD_FALL: busRdData = {{PAD_W{1'b0}}, fallMask};
      default: busRdData = '0;
    endcase
  end
endmodule

// File: rtl/pin_edge_event_dpath.sv
module pin_edge_event_dpath
  import pin_edge_event_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           strb,
  input  logic [NUM_PINS-1:0] wrBits,
  input  logic                bankBit,
  input  logic [NUM_PINS-1:0] pinRaw,
  output logic [NUM_PINS-1:0] riseMask,
  output logic [NUM_PINS-1:0] fallMask,
  output logic                bankEn,
  output logic [NUM_PINS-1:0] pinEvent
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncQ [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncLvl;
  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] riseNext, fallNext;
  logic [NUM_PINS-1:0] edgeHit;

  assign syncLvl = syncQ[LAST];

  // hidden masks: set by one alias, cleared by the other, clear has priority
  assign riseNext = (riseMask | (strb.setRise ? wrBits : '0))
                  & ~(strb.clrRise ? wrBits : '0);
  assign fallNext = (fallMask | (strb.setFall ? wrBits : '0))
                  & ~(strb.clrFall ? wrBits : '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseMask <= '0;
      fallMask <= '0;
      bankEn   <= 1'b0;
    end else begin
      riseMask <= riseNext;
      fallMask <= fallNext;
      if (strb.bankWr) bankEn <= bankBit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= pinRaw;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncLvl;
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic wentUp, wentDown;
    assign wentUp     = syncLvl[p] & ~prevQ[p];
    assign wentDown   = ~syncLvl[p] & prevQ[p];
    assign edgeHit[p] = (wentUp & riseMask[p]) | (wentDown & fallMask[p]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinEvent <= '0;
    else       pinEvent <= bankEn ? edgeHit : '0;
  end
endmodule

// File: rtl/pin_edge_event.sv
module pin_edge_event
  import pin_edge_event_pkg::*;
#(
  parameter int NUM_PINS    = 16,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinRaw,
  input  logic                busWrEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  output logic [NUM_PINS-1:0] pinEvent,
  output logic                irqAny
);
  wrStrobe_t           strb;
  logic [NUM_PINS-1:0] wrBits;
  logic                bankBit;
  logic [NUM_PINS-1:0] riseMask, fallMask;
  logic                bankEn;

  pin_edge_event_ctrl #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_ctrl (
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .riseMask(riseMask), .fallMask(fallMask), .bankEn(bankEn),
    .strb(strb), .wrBits(wrBits), .bankBit(bankBit), .busRdData(busRdData)
  );

  pin_edge_event_dpath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(wrBits), .bankBit(bankBit),
    .pinRaw(pinRaw), .riseMask(riseMask), .fallMask(fallMask),
    .bankEn(bankEn), .pinEvent(pinEvent)
  );

  assign irqAny = |pinEvent;
endmodule

// File: rtl/pin_edge_event_chk.sv
module pin_edge_event_chk
  import pin_edge_event_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWrEn,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busWrData,
  input logic [DATA_W-1:0]   busRdData,
  input logic [NUM_PINS-1:0] pinEvent,
  input logic [NUM_PINS-1:0] riseMask,
  input logic [NUM_PINS-1:0] fallMask,
  input logic                bankEn
);
  assert_rise_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_RISE_SET) |=>
      ((riseMask & $past(busWrData[NUM_PINS-1:0])) == $past(busWrData[NUM_PINS-1:0])));

  assert_fall_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_FALL_CLR) |=>
      ((fallMask & $past(busWrData[NUM_PINS-1:0])) == '0));

  assert_read_hi_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    busRdData[DATA_W-1:NUM_PINS] == '0);

  assert_bank_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    !bankEn |=> (pinEvent == '0));

  assert_armed_only_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pinEvent & ~($past(riseMask) | $past(fallMask))) == '0);
endmodule

bind pin_edge_event pin_edge_event_chk #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .busRdData(busRdData), .pinEvent(pinEvent),
  .riseMask(riseMask), .fallMask(fallMask), .bankEn(bankEn)
);

// File: tb/tb_pin_edge_event.sv
`timescale 1ns/1ps
module tb_pin_edge_event;
  localparam int NP = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NP-1:0] pinDrv = '0;
  logic          busWrEn = 1'b0;
  logic [7:0]    busAddr = 8'h00;
  logic [DW-1:0] busWrData = '0;
  logic [DW-1:0] busRdData;
  logic [NP-1:0] pinEvent;
  logic          irqAny;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pin_edge_event dut (
    .clk(clk), .rstN(rstN), .pinRaw(pinDrv), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .pinEvent(pinEvent), .irqAny(irqAny)
  );

  // reference state derived from the requirements
  logic [NP-1:0] mRise, mFall, m1, m2, m3, mEvt;
  logic          mEn;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mRise <= '0; mFall <= '0; m1 <= '0; m2 <= '0; m3 <= '0;
      mEvt <= '0; mEn <= 1'b0;
    end else begin
      mEvt <= mEn ? ((m2 & ~m3 & mRise) | (~m2 & m3 & mFall)) : '0;
      m3 <= m2; m2 <= m1; m1 <= pinDrv;
      if (busWrEn) begin
        case (busAddr)
          8'h24: mRise <= mRise | busWrData[NP-1:0];
          8'h28: mRise <= mRise & ~busWrData[NP-1:0];
          8'h2C: mFall <= mFall | busWrData[NP-1:0];
          8'h30: mFall <= mFall & ~busWrData[NP-1:0];
          8'h08: mEn   <= busWrData[0];
          default: ;
        endcase
      end
    end
  end

  function automatic logic [DW-1:0] expRead(input logic [7:0] a);
    case (a)
      8'h08:        return {{(DW-1){1'b0}}, mEn};
      8'h24, 8'h28: return {{(DW-NP){1'b0}}, mRise};
      8'h2C, 8'h30: return {{(DW-NP){1'b0}}, mFall};
      default:      return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R7 pin event timing", {16'h0, pinEvent}, {16'h0, mEvt});
      check("R8 combined interrupt", {31'h0, irqAny}, {31'h0, |mEvt});
      check("R4 read data", busRdData, expRead(busAddr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      nFails++; nChecks++;
      $display("FAIL watchdog expired R1..");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic busWrite(input logic [7:0] a, input logic [DW-1:0] d);
    @(negedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input string tag, input logic [7:0] a, input logic [DW-1:0] exp);
    @(negedge clk); #1;
    busAddr = a; #1;
    check(tag, busRdData, exp);
  endtask

  task automatic pinPulseCheck(input string tag, input logic [NP-1:0] lvl, input logic [NP-1:0] exp);
    @(negedge clk); #1;
    pinDrv = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check(tag, {16'h0, pinEvent}, {16'h0, exp});
    check("R8 irq with pulse", {31'h0, irqAny}, {31'h0, |exp});
    @(negedge clk); #2;
    check("R7 single cycle pulse", {16'h0, pinEvent}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset event", {16'h0, pinEvent}, 32'h0);
    busAddr = 8'h24; #1;
    check("R1 reset rise mask read", busRdData, 32'h0);
    rstN = 1'b1;
    readCheck("R1 reset bank read", 8'h08, 32'h0);
    readCheck("R1 reset fall mask read", 8'h30, 32'h0);

    // arm: pin3 rise only, pin4 fall only, pin5 both, pin6 none
    busWrite(8'h24, 32'hFFFF_0028);
    busWrite(8'h2C, 32'h0000_0030);
    readCheck("R2 rise set via clear alias read", 8'h28, 32'h0000_0028);
    readCheck("R4 fall read via set alias", 8'h2C, 32'h0000_0030);
    busWrite(8'h24, 32'h0);
    readCheck("R2 zero write keeps mask", 8'h24, 32'h0000_0028);

    // bank disabled: no events
    pinPulseCheck("R5 bank off suppresses", 16'h0078, 16'h0);
    pinPulseCheck("R5 bank off suppresses fall", 16'h0000, 16'h0);

    busWrite(8'h08, 32'hFFFF_FFFF);
    readCheck("R4 bank reads bit0 only", 8'h08, 32'h1);
    readCheck("R4 unmapped offset", 8'h10, 32'h0);

    pinPulseCheck("R6 rising edge encodings", 16'h0078, 16'h0028);
    pinPulseCheck("R6 falling edge encodings", 16'h0000, 16'h0030);

    busWrite(8'h28, 32'h0000_0008);
    readCheck("R3 rise clear", 8'h24, 32'h0000_0020);
    busWrite(8'h30, 32'h0000_0000);
    readCheck("R3 zero clear keeps mask", 8'h2C, 32'h0000_0030);
    pinPulseCheck("R3 cleared pin silent", 16'h0078, 16'h0020);

    // random phase, fixed seed
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      if ($urandom_range(3) == 0) pinDrv = pinDrv ^ 16'($urandom());
      busWrEn = ($urandom_range(9) < 3);
      case ($urandom_range(6))
        0: busAddr = 8'h08;
        1: busAddr = 8'h24;
        2: busAddr = 8'h28;
        3: busAddr = 8'h2C;
        4: busAddr = 8'h30;
        default: busAddr = 8'($urandom());
      endcase
      busWrData = $urandom();
      if (busAddr == 8'h08 && $urandom_range(3) != 0) busWrData[0] = 1'b1;
    end
    @(negedge clk); #1;
    busWrEn = 1'b0;
    repeat (5) @(negedge clk);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule